// File: doc/BRIEF.md
# Receive Descriptor Ring Writeback Engine

This block is the memory-facing half of a receive DMA. Software builds a ring of four-word descriptors in memory: status, control, buffer address and next pointer, each 32 bits. It arms each descriptor by setting the top bit of its status word. When a frame begins on the incoming byte stream, the engine reads the four words of the descriptor at its current pointer. If the descriptor is armed, the engine packs the frame bytes into 32-bit words and writes them into that descriptor's buffer. At the end of the frame it writes a single status word that gives back ownership and reports the frame length and any errors. It then follows the next pointer.

A descriptor that is not armed when a frame arrives is not touched. The frame is drained from the stream and a missed-frame count goes up. Two controls gate the engine. A run control loads the ring pointer from a base address while it is low. A receive enable makes the engine drop new frames silently while it is low. The memory port is a simple request port with no stall: read data returns one cycle after the read request.

Top module: `rxdr_engine`

## Requirements
- R1: While reset is asserted and right after it, `s_ready` is 0, `mem_req` is 0 and `missed_cnt` is 0.
- R2: When a frame starts, the engine reads the status, control, buffer and next words at offsets 0, 4, 8 and 12 from the ring pointer. It stores the frame only if status bit 31 is 1, and the status word it writes back has bit 31 cleared.
- R3: The writeback is one write to offset 0 of the descriptor. It carries the received byte count in bits [29:16], the runt flag in bit 0, the overflow flag in bit 1, and the OR of those two flags in bit 15. All other bits are 0.
- R4: A frame of fewer than 64 bytes sets the runt flag (bit 0) and the error bit (bit 15). A frame of 64 bytes or more leaves both clear.
- R5: The buffer size is taken from control bits [11:0]. Bytes at index size or above are not written to memory. Such a frame sets the overflow flag (bit 1) and the error bit (bit 15), and its length field still reports the full received count.
- R6: Frame byte k is written to address buffer+k. Bytes are little-endian within each 32-bit word, so byte k sits in bits [8*(k%4)+7 : 8*(k%4)] of the word at buffer+4*(k/4). Unused upper bytes of the last partial word are written as 0.
- R7: After a writeback, the ring pointer becomes the descriptor's next word, so a ring whose last next word points at the first descriptor wraps around.
- R8: If the fetched status bit 31 is 0, the whole frame is consumed from the stream. Nothing is written to memory, `missed_cnt` increases by one, and the ring pointer does not move.
- R9: While `dma_run` is 0, the ring pointer follows `ring_base`. A frame that starts while `dma_run` or `rx_en` is 0 is consumed with no memory access, no change to `missed_cnt` and no pointer movement.
- R10: `s_ready` stays 0 while the descriptor is being fetched, which takes at least five cycles from the frame's first byte being offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dma_run | input | 1 | Run control; while 0 the ring pointer follows `ring_base` and frames are dropped |
| rx_en | input | 1 | Receive enable; while 0 new frames are dropped |
| ring_base | input | ADDR_W | Address of the first descriptor |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_sof | input | 1 | Marks the first byte of a frame |
| s_eof | input | 1 | Marks the last byte of a frame |
| s_ready | output | 1 | Engine accepts the offered byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |
| missed_cnt | output | MISS_W | Count of frames that met an unarmed descriptor |

## Verification
The assertions assume a well-formed stream. A start marker appears only on the first byte of a frame, every frame ends with an end marker, and no byte is offered outside a frame. They also assume that memory returns read data exactly one cycle after the request, and that descriptor and buffer addresses are word aligned. The bench drives only complete frames built by one task that places both markers itself. Its memory model answers reads with a one-cycle register. Every descriptor and buffer it places starts on a 4-byte boundary, and it uses buffer sizes that are multiples of four.

// File: rtl/rxdr_pkg.sv
package rxdr_pkg;

   localparam int LEN_W     = 14;
   localparam int LEN_LSB   = 16;
   localparam int OWN_BIT   = 31;
   localparam int ERR_BIT   = 15;
   localparam int OVF_BIT   = 1;
   localparam int RUNT_BIT  = 0;
   localparam int DESC_WORDS = 4;

   typedef enum logic [2:0] {
      S_IDLE,
      S_FETCH,
      S_RECV,
      S_WB,
      S_DROP
   } rxdr_state_e;

endpackage

// File: rtl/rxdr_lane_packer.sv
module rxdr_lane_packer #(
   parameter int LANES = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   we_byte,
   input  logic [$clog2(LANES)-1:0] lane,
   input  logic [7:0]             din,
   input  logic                   flush,
   output logic [8*LANES-1:0]     word_out
);

   logic [7:0] hold [LANES];

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic hit;
      assign hit = we_byte && (lane == l[$clog2(LANES)-1:0]);
      assign word_out[8*l +: 8] = hit ? din : hold[l];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             hold[l] <= '0;
         else if (clr || flush)  hold[l] <= '0;
         else if (hit)           hold[l] <= din;
      end
   end

endmodule

// File: rtl/rxdr_miss_counter.sv
module rxdr_miss_counter #(
   parameter int MISS_W   = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   output logic [MISS_W-1:0] count
);

   logic step;

   if (SATURATE) begin : g_sat
      assign step = inc && (count != {MISS_W{1'b1}});
   end else begin : g_wrap
      assign step = inc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count <= '0;
      else if (step) count <= count + 1'b1;
   end

endmodule

// File: rtl/rxdr_engine.sv
module rxdr_engine
   import rxdr_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int SIZE_W        = 12,
   parameter int MISS_W        = 16,
   parameter int RUNT_MIN      = 64,
   parameter bit MISS_SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dma_run,
   input  logic              rx_en,
   input  logic [ADDR_W-1:0] ring_base,
   input  logic              s_valid,
   input  logic [7:0]        s_data,
   input  logic              s_sof,
   input  logic              s_eof,
   output logic              s_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   output logic [MISS_W-1:0] missed_cnt
);

   localparam int WORD_BYTES = 4;
   localparam int LANE_W     = $clog2(WORD_BYTES);
   localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

   if (SIZE_W > LEN_W || ADDR_W > 32 || ADDR_W < 8 || RUNT_MIN < 1 || MISS_W < 1) begin : g_bad_cfg
      $error("rxdr_engine: unsupported parameter combination");
   end

   rxdr_state_e        st;
   logic [ADDR_W-1:0]  cur_ptr, d_buf, d_next;
   logic [31:0]        d_status;
   logic [SIZE_W-1:0]  d_size;
   logic [2:0]         fc;
   logic [LEN_W-1:0]   cnt, len_r, cnt_inc, size_x;
   logic               ovf_r, beat, in_range, byte_wr, miss_inc;
   logic               runt_w;
   logic [31:0]        pack_word, wb_word;

   assign s_ready  = (st == S_RECV) || (st == S_DROP);
   assign beat     = s_valid && s_ready;
   assign cnt_inc  = (cnt == LEN_MAX) ? cnt : cnt + 1'b1;
   assign size_x   = LEN_W'(d_size);
   assign in_range = cnt < size_x;
   assign byte_wr  = (st == S_RECV) && beat && in_range &&
                     ((cnt[LANE_W-1:0] == LANE_W'(WORD_BYTES-1)) || s_eof ||
                      (cnt == size_x - 1'b1));
   assign miss_inc = (st == S_FETCH) && (fc == 3'd4) && !d_status[OWN_BIT];

   rxdr_lane_packer #(.LANES(WORD_BYTES)) u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (st == S_FETCH),
      .we_byte  ((st == S_RECV) && beat && in_range),
      .lane     (cnt[LANE_W-1:0]),
      .din      (s_data),
      .flush    (byte_wr),
      .word_out (pack_word)
   );

   rxdr_miss_counter #(.MISS_W(MISS_W), .SATURATE(MISS_SATURATE)) u_miss (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (miss_inc),
      .count (missed_cnt)
   );

   assign runt_w = len_r < LEN_W'(RUNT_MIN);

   always_comb begin
      wb_word = '0;
      wb_word[LEN_LSB +: LEN_W] = len_r;
      wb_word[RUNT_BIT] = runt_w;
      wb_word[OVF_BIT]  = ovf_r;
      wb_word[ERR_BIT]  = runt_w || ovf_r;
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = cur_ptr;
      mem_wdata = '0;
      if ((st == S_FETCH) && (fc < 3'(DESC_WORDS))) begin
         mem_req  = 1'b1;
         mem_addr = cur_ptr + ADDR_W'({fc[1:0], 2'b00});
      end else if (byte_wr) begin
         mem_req   = 1'b1;
         mem_we    = 1'b1;
         mem_addr  = d_buf + ADDR_W'({cnt[LEN_W-1:LANE_W], {LANE_W{1'b0}}});
         mem_wdata = pack_word;
      end else if (st == S_WB) begin
         mem_req   = 1'b1;
         mem_we    = 1'b1;
         mem_wdata = wb_word;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         cur_ptr  <= '0;
         d_buf    <= '0;
         d_next   <= '0;
         d_status <= '0;
         d_size   <= '0;
         fc       <= '0;
         cnt      <= '0;
         len_r    <= '0;
         ovf_r    <= 1'b0;
      end else begin
         case (st)
            S_IDLE: begin
               fc <= '0;
               if (s_valid && s_sof) st <= (dma_run && rx_en) ? S_FETCH : S_DROP;
            end
            S_FETCH: begin
               fc <= fc + 1'b1;
               case (fc)
                  3'd1: d_status <= mem_rdata;
                  3'd2: d_size   <= mem_rdata[SIZE_W-1:0];
                  3'd3: d_buf    <= mem_rdata[ADDR_W-1:0];
                  3'd4: d_next   <= mem_rdata[ADDR_W-1:0];
                  default: ;
               endcase
               if (fc == 3'd4) begin
                  cnt   <= '0;
                  ovf_r <= 1'b0;
                  st    <= d_status[OWN_BIT] ? S_RECV : S_DROP;
               end
            end
            S_RECV: begin
               if (beat) begin
                  cnt <= cnt_inc;
                  if (!in_range) ovf_r <= 1'b1;
                  if (s_eof) begin
                     len_r <= cnt_inc;
                     st    <= S_WB;
                  end
               end
            end
            S_WB: begin
               cur_ptr <= d_next;
               st      <= S_IDLE;
            end
            S_DROP: begin
               if (beat && s_eof) st <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
         if (!dma_run) cur_ptr <= ring_base;
      end
   end

endmodule

// File: rtl/rxdr_engine_chk.sv
module rxdr_engine_chk #(
   parameter int MISS_W   = 16,
   parameter int LEN_W    = 14,
   parameter int RUNT_MIN = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              s_ready,
   input logic              mem_req,
   input logic              mem_we,
   input logic [31:0]       mem_wdata,
   input logic [MISS_W-1:0] missed_cnt,
   input logic              wb_cycle,
   input logic              fetch_cycle,
   input logic              byte_wr,
   input logic [LEN_W-1:0]  byte_idx,
   input logic [LEN_W-1:0]  size_lim
);

   AST_OWN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      wb_cycle |-> (mem_req && mem_we && !mem_wdata[31])); // R2

   AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
      wb_cycle |-> (mem_wdata[15] == (mem_wdata[0] || mem_wdata[1]))); // R3

   AST_RUNT_MATCHES_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      wb_cycle |-> (mem_wdata[0] == (mem_wdata[29:16] < 14'(RUNT_MIN)))); // R4

   AST_WRITE_IN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      byte_wr |-> (byte_idx < size_lim)); // R5

   AST_MISS_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (missed_cnt != $past(missed_cnt)) |-> (missed_cnt == MISS_W'($past(missed_cnt) + 1'b1))); // R8

   AST_NO_READY_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_cycle |-> !s_ready); // R10

endmodule

bind rxdr_engine rxdr_engine_chk #(
   .MISS_W   (MISS_W),
   .LEN_W    (rxdr_pkg::LEN_W),
   .RUNT_MIN (RUNT_MIN)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .s_ready     (s_ready),
   .mem_req     (mem_req),
   .mem_we      (mem_we),
   .mem_wdata   (mem_wdata),
   .missed_cnt  (missed_cnt),
   .wb_cycle    (st == rxdr_pkg::S_WB),
   .fetch_cycle (st == rxdr_pkg::S_FETCH),
   .byte_wr     (byte_wr),
   .byte_idx    (cnt),
   .size_lim    (size_x)
);

// File: tb/rxdr_engine_bench.sv
`timescale 1ns/1ps
module rxdr_engine_bench;

   localparam int ADDR_W = 32;
   localparam int MISS_W = 16;
   localparam int NV     = 8;
   localparam logic [31:0] SENT = 32'hA5A5_A5A5;
   localparam logic [31:0] IDLE_MARK = 32'h0000_00EE;

   // {armed, buffer size[11:0], frame length[13:0]}
   localparam logic [26:0] VEC [NV] = '{
      {1'b1, 12'd128, 14'd64},
      {1'b1, 12'd128, 14'd63},
      {1'b1, 12'd128, 14'd130},
      {1'b1, 12'd128, 14'd128},
      {1'b0, 12'd0,   14'd70},
      {1'b1, 12'd256, 14'd101},
      {1'b1, 12'd64,  14'd1},
      {1'b1, 12'd60,  14'd200}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dma_run = 1'b0, rx_en = 1'b0;
   logic [ADDR_W-1:0] ring_base = '0;
   logic s_valid = 1'b0, s_sof = 1'b0, s_eof = 1'b0;
   logic [7:0] s_data = '0;
   logic s_ready, mem_req, mem_we;
   logic [ADDR_W-1:0] mem_addr;
   logic [31:0] mem_wdata, mem_rdata;
   logic [MISS_W-1:0] missed_cnt;

   logic tb_we = 1'b0;
   logic [31:0] tb_addr = '0, tb_wdata = '0;
   logic [31:0] mem [1024];
   int wr_cnt = 0;
   int checks = 0, fails = 0, vectors = 0;

   always #10 clk = ~clk;

   rxdr_engine u_rxdr_engine (
      .clk(clk), .rst_n(rst_n), .dma_run(dma_run), .rx_en(rx_en),
      .ring_base(ring_base), .s_valid(s_valid), .s_data(s_data),
      .s_sof(s_sof), .s_eof(s_eof), .s_ready(s_ready), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .missed_cnt(missed_cnt)
   );

   always @(posedge clk) begin
      if (mem_req && mem_we) begin
         mem[mem_addr[11:2]] <= mem_wdata;
         wr_cnt <= wr_cnt + 1;
      end else if (tb_we) begin
         mem[tb_addr[11:2]] <= tb_wdata;
      end
      if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[11:2]];
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic poke(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      tb_we = 1'b1; tb_addr = a; tb_wdata = d;
      @(posedge clk);
      #1 tb_we = 1'b0;
   endtask

   function automatic logic [31:0] buf_of(input int d);
      return 32'h400 * (d + 1);
   endfunction

   task automatic prep_desc(input int d, input bit armed, input int size);
      logic [31:0] base;
      base = 32'(d * 16);
      poke(base,      armed ? 32'h8000_0000 : IDLE_MARK);
      poke(base + 4,  32'(size));
      poke(base + 8,  buf_of(d));
      poke(base + 12, 32'(((d + 1) % 3) * 16));
      for (int w = 0; w < 80; w++) poke(buf_of(d) + 32'(4 * w), SENT);
   endtask

   task automatic send_frame(input int len, input int seed, output int waits);
      waits = 0;
      for (int k = 0; k < len; k++) begin
         @(negedge clk);
         s_valid = 1'b1; s_data = 8'(seed * 16 + k);
         s_sof = (k == 0); s_eof = (k == len - 1);
         #1;
         while (!s_ready) begin
            if (k == 0) waits++;
            @(negedge clk); #1;
         end
         @(posedge clk);
      end
      @(negedge clk);
      s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   function automatic logic [31:0] exp_status(input int len, input int size);
      logic [31:0] s;
      logic runt, ovf;
      runt = (len < 64);
      ovf  = (len > size);
      s = '0;
      s[29:16] = 14'(len);
      s[0] = runt; s[1] = ovf; s[15] = runt | ovf;
      return s;
   endfunction

   // R6: byte k at buf+k, little-endian, zero padding in last partial word
   task automatic check_frame(input int d, input int len, input int size, input int seed);
      logic [31:0] st, w, e;
      int nb, bad;
      st = mem[d * 4];
      chk(st == exp_status(len, size), "R3 status word", st, exp_status(len, size));
      chk(!st[31], "R2 ownership released", st[31], 0);
      chk(st[0] == (len < 64), "R4 runt flag", st[0], (len < 64));
      chk(st[1] == (len > size), "R5 overflow flag", st[1], (len > size));
      nb = (len < size) ? len : size;
      bad = 0;
      for (int wi = 0; wi < (nb + 3) / 4; wi++) begin
         w = mem[(buf_of(d) >> 2) + wi];
         for (int l = 0; l < 4; l++) begin
            e[8*l +: 8] = (4 * wi + l < nb) ? 8'(seed * 16 + 4 * wi + l) : 8'h00;
         end
         if (w != e) bad++;
      end
      chk(bad == 0, "R6 buffer contents", bad, 0);
      if (len > size) begin
         w = mem[(buf_of(d) >> 2) + size / 4];
         chk(w == SENT, "R5 no write past buffer size", w, SENT);
      end
   endtask

   initial begin
      #4_000_000;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      int exp_d, waits, w0;
      logic [MISS_W-1:0] m0;
      logic [31:0] st;
      exp_d = 0;

      repeat (3) @(negedge clk);
      chk(s_ready == 1'b0, "R1 s_ready in reset", s_ready, 0);
      chk(mem_req == 1'b0, "R1 mem_req in reset", mem_req, 0);
      chk(missed_cnt == '0, "R1 missed_cnt in reset", missed_cnt, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(s_ready == 1'b0 && mem_req == 1'b0, "R1 idle after reset", {s_ready, mem_req}, 0);
      dma_run = 1'b1; rx_en = 1'b1;

      for (int v = 0; v < NV; v++) begin
         bit armed;
         int size, len;
         armed = VEC[v][26];
         size  = int'(VEC[v][25:14]);
         len   = int'(VEC[v][13:0]);
         prep_desc(exp_d, armed, size);
         w0 = wr_cnt; m0 = missed_cnt;
         send_frame(len, v, waits);
         if (armed) begin
            check_frame(exp_d, len, size, v);
            if (v == 0) chk(waits >= 5, "R10 stalled during fetch", waits, 5);
            if (v == 3) chk(exp_d == 0 && mem[0][29:16] == 14'd128, "R7 ring wrapped to first", mem[0], 32'h0080_0000);
            exp_d = (exp_d + 1) % 3;
         end else begin
            st = mem[exp_d * 4];
            chk(st == IDLE_MARK, "R8 unarmed status untouched", st, IDLE_MARK);
            chk(wr_cnt == w0, "R8 no memory write", wr_cnt - w0, 0);
            chk(missed_cnt == m0 + 1'b1, "R8 missed count", missed_cnt, m0 + 1'b1);
         end
         vectors++;
      end

      // R9: receive disabled, frame dropped silently
      rx_en = 1'b0;
      prep_desc(exp_d, 1'b1, 128);
      w0 = wr_cnt; m0 = missed_cnt;
      send_frame(70, 9, waits);
      chk(wr_cnt == w0, "R9 disabled no write", wr_cnt - w0, 0);
      chk(missed_cnt == m0, "R9 disabled no miss", missed_cnt, m0);
      chk(mem[exp_d * 4] == 32'h8000_0000, "R9 descriptor still armed", mem[exp_d * 4], 32'h8000_0000);
      vectors++;
      rx_en = 1'b1;
      send_frame(80, 10, waits);
      check_frame(exp_d, 80, 128, 10);
      exp_d = (exp_d + 1) % 3;
      vectors++;

      // R9: stop, new base, restart
      @(negedge clk);
      dma_run = 1'b0;
      ring_base = 32'h10;
      repeat (2) @(negedge clk);
      dma_run = 1'b1;
      exp_d = 1;
      prep_desc(0, 1'b1, 128);
      prep_desc(exp_d, 1'b1, 128);
      send_frame(72, 11, waits);
      chk(mem[4][31] == 1'b0 && mem[0][31] == 1'b1, "R9 restart at ring_base", {mem[0][31], mem[4][31]}, 2'b10);
      check_frame(exp_d, 72, 128, 11);
      vectors++;

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule